// File: doc/BRIEF.md
# PHY Reset and Autonegotiation Sequencer

This block runs two housekeeping sequences on an Ethernet PHY through a request/acknowledge register port. It takes the place of a software loop. A command picks one of two operations. The first is a software reset: the block sets the reset flag and waits until the PHY clears it. The second restarts autonegotiation: the block enables and restarts autonegotiation, then waits until the PHY reports the negotiation finished. Each command carries a timeout budget.

Both operations start with a read-modify-write of the PHY control register, so every bit that the operation does not own keeps its value. After the write, the block sleeps for a fixed poll interval and takes that interval off the budget. It then reads the register that shows completion. The loop ends on success, on a failed read, or when the budget is used up. One result code is returned with a single-cycle done pulse: OK = 0, FAIL = 1, TIMEOUT = 2.

The serial management bus itself sits outside this block. Each register access is one transaction: the block holds `regReq` until `regAck`, and read data and the error flag are valid in the acknowledge cycle.

Top module: `phy_cmd_sequencer`

## Requirements
- R1: A reset command (`cmdOp` = 0) reads control register address `CTRL_ADDR` (0), then writes back the read value with bit 15 set. Both accesses use `cmdPhyAddr` as the PHY address.
- R2: An autonegotiation command (`cmdOp` = 1) reads the control register, then writes back the read value with bits 12 and 9 set. All other bits are unchanged.
- R3: After the write, and after each unsuccessful poll, `regReq` stays low for exactly `POLL_CYCLES` cycles before the next poll read. Each such wait takes `POLL_CYCLES` off the remaining budget, which saturates at zero.
- R4: A reset command polls the control register. It ends with OK on the first poll read that shows bit 15 as 0.
- R5: An autonegotiation command polls status register address `STATUS_ADDR` (1). It ends with OK on the first poll read that shows bit `AN_DONE_BIT` (5) as 1.
- R6: If a poll read is unsuccessful and the budget has reached zero, the result is TIMEOUT. The number of poll reads is therefore ceil(timeout / `POLL_CYCLES`).
- R7: An autonegotiation command with a timeout of zero ends with OK right after the write, with no poll read.
- R8: A reset command with a timeout of zero ends with TIMEOUT right after the write, with no poll read.
- R9: A read acknowledged with `regErr` = 1 ends the command at once with FAIL. If the error is on the first control read, no write is issued.
- R10: `busy` rises in the cycle after a command is accepted and stays high until the done cycle. `done` is high for exactly one cycle with `result` valid, and `busy` is low in the next cycle.
- R11: `cmdValid` while `busy` is high is ignored: no extra access is made and no second result is produced.
- R12: A raised `regReq` stays high with address, direction and write data unchanged until `regAck`. The error flag on a write acknowledge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command strobe, taken when not busy |
| cmdOp | input | 1 | 0 = PHY reset, 1 = restart autonegotiation |
| cmdPhyAddr | input | 5 | Target PHY address |
| cmdTimeout | input | TIMEOUT_W | Timeout budget in clock cycles |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 OK, 1 FAIL, 2 TIMEOUT; valid with done |
| regReq | output | 1 | Register access request |
| regWrite | output | 1 | 1 = write, 0 = read |
| regPhyAddr | output | 5 | PHY address of the access |
| regAddr | output | 5 | Register address of the access |
| regWdata | output | 16 | Write data |
| regAck | input | 1 | Access acknowledge, one cycle |
| regRdata | input | 16 | Read data, valid with regAck |
| regErr | input | 1 | Read error, valid with regAck |

## Verification
The assertions assume that the register responder raises `regAck` only while `regReq` is high, for one cycle per request. They also assume that `regAck` never comes in the same cycle as a new request's first cycle. The bench's PHY model follows these rules: it acknowledges one cycle after it sees a request, and never twice in a row. The bench changes `cmdValid` and the command fields only at falling edges. It drives `cmdValid` during a busy period only in the scenario that checks the command is ignored.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_FAIL    = 2'd1,
    RES_TIMEOUT = 2'd2
  } result_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_CTRL,
    S_WR_CTRL,
    S_WAIT,
    S_POLL,
    S_DONE
  } state_e;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic    loadCmd;
    logic    captureRead;
    logic    startWait;
    logic    tickWait;
    logic    setResult;
    result_e resultCode;
  } dp_ctrl_t;

  localparam int RESET_BIT   = 15;
  localparam int AN_EN_BIT   = 12;
  localparam int AN_RST_BIT  = 9;

endpackage

// File: rtl/phy_seq_datapath.sv
module phy_seq_datapath
  import phy_seq_pkg::*;
#(
  parameter int TIMEOUT_W   = 16,
  parameter int POLL_CYCLES = 100,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16,
  parameter int AN_DONE_BIT = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dp_ctrl_t             ctl,
  input  logic                 cmdOp,
  input  logic [ADDR_W-1:0]    cmdPhyAddr,
  input  logic [TIMEOUT_W-1:0] cmdTimeout,
  input  logic [DATA_W-1:0]    regRdata,
  output logic                 opAutoneg,
  output logic [ADDR_W-1:0]    phyAddr,
  output logic [DATA_W-1:0]    writeData,
  output logic                 budgetZero,
  output logic                 waitDone,
  output logic                 pollSuccess,
  output result_e              resultReg
);

  localparam int CNT_W = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
  localparam logic [CNT_W-1:0]     WAIT_LOAD = CNT_W'(POLL_CYCLES - 1);
  localparam logic [TIMEOUT_W-1:0] POLL_B    = TIMEOUT_W'(POLL_CYCLES);

  logic [DATA_W-1:0]    shadow;
  logic [TIMEOUT_W-1:0] budget;
  logic [CNT_W-1:0]     waitCnt;
  logic [DATA_W-1:0]    setMask;

  always_comb begin
    setMask = '0;
    if (opAutoneg) begin
      setMask[AN_EN_BIT]  = 1'b1;
      setMask[AN_RST_BIT] = 1'b1;
    end else begin
      setMask[RESET_BIT]  = 1'b1;
    end
  end

  assign writeData   = shadow | setMask;
  assign budgetZero  = (budget == '0);
  assign waitDone    = (waitCnt == '0);
  assign pollSuccess = opAutoneg ? regRdata[AN_DONE_BIT] : !regRdata[RESET_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opAutoneg <= 1'b0;
      phyAddr   <= '0;
      shadow    <= '0;
      budget    <= '0;
      waitCnt   <= '0;
      resultReg <= RES_OK;
    end else begin
      if (ctl.loadCmd) begin
        opAutoneg <= cmdOp;
        phyAddr   <= cmdPhyAddr;
        budget    <= cmdTimeout;
      end
      if (ctl.captureRead) shadow <= regRdata;
      if (ctl.startWait) begin
        waitCnt <= WAIT_LOAD;
      end else if (ctl.tickWait) begin
        if (waitCnt == '0) begin
          budget <= (budget > POLL_B) ? budget - POLL_B : '0;
        end else begin
          waitCnt <= waitCnt - 1'b1;
        end
      end
      if (ctl.setResult) resultReg <= ctl.resultCode;
    end
  end

endmodule

// File: rtl/phy_seq_control.sv
module phy_seq_control
  import phy_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdValid,
  input  logic     regAck,
  input  logic     regErr,
  input  logic     opAutoneg,
  input  logic     budgetZero,
  input  logic     waitDone,
  input  logic     pollSuccess,
  output dp_ctrl_t ctl,
  output logic     busy,
  output logic     done,
  output logic     regReq,
  output logic     regWrite,
  output logic     selStatus
);

  state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (cmdValid) begin
          ctl.loadCmd = 1'b1;
          nextState   = S_RD_CTRL;
        end
      end
      S_RD_CTRL: begin
        if (regAck) begin
          if (regErr) begin
            ctl.setResult  = 1'b1;
            ctl.resultCode = RES_FAIL;
            nextState      = S_DONE;
          end else begin
            ctl.captureRead = 1'b1;
            nextState       = S_WR_CTRL;
          end
        end
      end
      S_WR_CTRL: begin
        if (regAck) begin
          if (budgetZero) begin
            ctl.setResult  = 1'b1;
            ctl.resultCode = opAutoneg ? RES_OK : RES_TIMEOUT;
            nextState      = S_DONE;
          end else begin
            ctl.startWait = 1'b1;
            nextState     = S_WAIT;
          end
        end
      end
      S_WAIT: begin
        ctl.tickWait = 1'b1;
        if (waitDone) nextState = S_POLL;
      end
      S_POLL: begin
        if (regAck) begin
          if (regErr) begin
            ctl.setResult  = 1'b1;
            ctl.resultCode = RES_FAIL;
            nextState      = S_DONE;
          end else if (pollSuccess) begin
            ctl.setResult  = 1'b1;
            ctl.resultCode = RES_OK;
            nextState      = S_DONE;
          end else if (budgetZero) begin
            ctl.setResult  = 1'b1;
            ctl.resultCode = RES_TIMEOUT;
            nextState      = S_DONE;
          end else begin
            ctl.startWait = 1'b1;
            nextState     = S_WAIT;
          end
        end
      end
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  assign busy      = (state != S_IDLE);
  assign done      = (state == S_DONE);
  assign regReq    = (state == S_RD_CTRL) || (state == S_WR_CTRL) || (state == S_POLL);
  assign regWrite  = (state == S_WR_CTRL);
  assign selStatus = (state == S_POLL) && opAutoneg;

endmodule

// File: rtl/phy_cmd_sequencer.sv
module phy_cmd_sequencer
  import phy_seq_pkg::*;
#(
  parameter int          TIMEOUT_W   = 16,
  parameter int          POLL_CYCLES = 100,
  parameter logic [4:0]  CTRL_ADDR   = 5'd0,
  parameter logic [4:0]  STATUS_ADDR = 5'd1,
  parameter int          AN_DONE_BIT = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic                 cmdOp,
  input  logic [4:0]           cmdPhyAddr,
  input  logic [TIMEOUT_W-1:0] cmdTimeout,
  output logic                 busy,
  output logic                 done,
  output logic [1:0]           result,
  output logic                 regReq,
  output logic                 regWrite,
  output logic [4:0]           regPhyAddr,
  output logic [4:0]           regAddr,
  output logic [15:0]          regWdata,
  input  logic                 regAck,
  input  logic [15:0]          regRdata,
  input  logic                 regErr
);

  dp_ctrl_t ctl;
  logic     opAutoneg, budgetZero, waitDone, pollSuccess, selStatus;
  result_e  resultReg;

  phy_seq_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .regAck     (regAck),
    .regErr     (regErr),
    .opAutoneg  (opAutoneg),
    .budgetZero (budgetZero),
    .waitDone   (waitDone),
    .pollSuccess(pollSuccess),
    .ctl        (ctl),
    .busy       (busy),
    .done       (done),
    .regReq     (regReq),
    .regWrite   (regWrite),
    .selStatus  (selStatus)
  );

  phy_seq_datapath #(
    .TIMEOUT_W  (TIMEOUT_W),
    .POLL_CYCLES(POLL_CYCLES),
    .ADDR_W     (5),
    .DATA_W     (16),
    .AN_DONE_BIT(AN_DONE_BIT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .cmdOp      (cmdOp),
    .cmdPhyAddr (cmdPhyAddr),
    .cmdTimeout (cmdTimeout),
    .regRdata   (regRdata),
    .opAutoneg  (opAutoneg),
    .phyAddr    (regPhyAddr),
    .writeData  (regWdata),
    .budgetZero (budgetZero),
    .waitDone   (waitDone),
    .pollSuccess(pollSuccess),
    .resultReg  (resultReg)
  );

  assign regAddr = selStatus ? STATUS_ADDR : CTRL_ADDR;
  assign result  = resultReg;

endmodule

// File: rtl/phy_cmd_sequencer_checker.sv
module phy_cmd_sequencer_checker #(
  parameter logic [4:0] CTRL_ADDR = 5'd0
) (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic        busy,
  input logic        done,
  input logic        regReq,
  input logic        regWrite,
  input logic [4:0]  regAddr,
  input logic [15:0] regWdata,
  input logic        regAck
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && !busy); // R10

  AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy); // R10

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid) |=> busy); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !regReq); // R11

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regAck) |=> regReq && $stable(regAddr) && $stable(regWrite) && $stable(regWdata)); // R12

  AST_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && regWrite) |-> (regAddr == CTRL_ADDR)); // R1

  AST_WRITE_SETS_BITS: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && regWrite) |-> (regWdata[15] || (regWdata[12] && regWdata[9]))); // R2

endmodule

bind phy_cmd_sequencer phy_cmd_sequencer_checker #(.CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cmdValid(cmdValid),
  .busy    (busy),
  .done    (done),
  .regReq  (regReq),
  .regWrite(regWrite),
  .regAddr (regAddr),
  .regWdata(regWdata),
  .regAck  (regAck)
);

// File: tb/tb_phy_cmd_sequencer.sv
`timescale 1ns/1ps
module tb_phy_cmd_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int POLL       = 8;
  localparam int TW         = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic          cmdOp = 1'b0;
  logic [4:0]    cmdPhyAddr = '0;
  logic [TW-1:0] cmdTimeout = '0;
  logic          busy, done;
  logic [1:0]    result;
  logic          regReq, regWrite;
  logic [4:0]    regPhyAddr, regAddr;
  logic [15:0]   regWdata;
  logic          regAck = 1'b0;
  logic [15:0]   regRdata = '0;
  logic          regErr = 1'b0;

  int checks = 0;
  int fails  = 0;

  // PHY model configuration (written by tasks only)
  logic [15:0] ctrlInit  = 16'h0000;
  int          resetHold = 0;
  int          anHold    = 0;
  int          errAt     = 0;

  // PHY model state (written by the model only)
  logic [15:0] ctrlReg;
  int readIdx, writeCnt, ctrlPolls, statPolls, gapCnt;
  logic pollSeen;
  logic [15:0] lastWdata;
  logic [4:0]  lastPhy;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_cmd_sequencer #(.TIMEOUT_W(TW), .POLL_CYCLES(POLL)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdPhyAddr(cmdPhyAddr), .cmdTimeout(cmdTimeout), .busy(busy), .done(done),
    .result(result), .regReq(regReq), .regWrite(regWrite), .regPhyAddr(regPhyAddr),
    .regAddr(regAddr), .regWdata(regWdata), .regAck(regAck), .regRdata(regRdata),
    .regErr(regErr)
  );

  always @(posedge clk) begin
    if (!rstN) begin
      regAck <= 1'b0; regErr <= 1'b0;
      ctrlReg = '0; readIdx = 0; writeCnt = 0; ctrlPolls = 0; statPolls = 0;
      gapCnt = 0; pollSeen = 1'b0; lastWdata = '0; lastPhy = '0;
    end else begin
      if (cmdValid && !busy) begin
        ctrlReg = ctrlInit; readIdx = 0; writeCnt = 0; ctrlPolls = 0;
        statPolls = 0; gapCnt = 0; pollSeen = 1'b0;
      end
      if (writeCnt > 0 && !pollSeen && !regReq) gapCnt++;
      regAck <= 1'b0;
      regErr <= 1'b0;
      if (regReq && !regAck) begin
        regAck <= 1'b1;
        lastPhy = regPhyAddr;
        if (regWrite) begin
          writeCnt++;
          lastWdata = regWdata;
          ctrlReg   = regWdata;
        end else begin
          logic [15:0] rd;
          readIdx++;
          regErr <= (readIdx == errAt);
          if (writeCnt > 0) pollSeen = 1'b1;
          if (regAddr == 5'd1) begin
            rd = 16'h7809;
            rd[5] = (statPolls >= anHold);
            statPolls++;
          end else begin
            rd = ctrlReg;
            if (writeCnt > 0) begin
              if (ctrlPolls >= resetHold) rd[15] = 1'b0;
              ctrlPolls++;
            end
          end
          regRdata <= rd;
        end
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  // issue a command and wait for done; optionally pulse cmdValid while busy
  task automatic runCmd(input logic op, input int tmo, input logic intrude,
                        output int res);
    int n;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdTimeout = TW'(tmo); cmdPhyAddr = 5'd19;
    @(negedge clk);
    cmdValid = 1'b0;
    check("R10", "busy after accept", busy, 1);
    if (intrude) begin
      @(negedge clk);
      cmdValid = 1'b1; cmdOp = ~op; cmdTimeout = 16'd0;
      @(negedge clk);
      cmdValid = 1'b0;
    end
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check("R10", "done seen", done, 1);
    res = result;
    @(negedge clk);
    check("R10", "done one cycle", done, 0);
    check("R10", "busy low after done", busy, 0);
  endtask

  task automatic tReset();
    int res;
    check("R10", "reset busy", busy, 0);
    check("R10", "reset done", done, 0);
    check("R12", "reset regReq", regReq, 0);
  endtask

  task automatic tResetOk();
    int res;
    ctrlInit = 16'h1140; resetHold = 2; anHold = 0; errAt = 0;
    runCmd(1'b0, 100, 1'b0, res);
    check("R4", "reset result OK", res, 0);
    check("R1", "reset write data", lastWdata, 16'h9140);
    check("R1", "phy address", lastPhy, 19);
    check("R4", "reset polls", ctrlPolls, 3);
    check("R3", "idle gap before poll", gapCnt, POLL);
  endtask

  task automatic tAnOk();
    int res;
    ctrlInit = 16'h0100; resetHold = 0; anHold = 1; errAt = 0;
    runCmd(1'b1, 100, 1'b0, res);
    check("R5", "autoneg result OK", res, 0);
    check("R2", "autoneg write data", lastWdata, 16'h1300);
    check("R5", "status polls", statPolls, 2);
    check("R5", "no control polls", ctrlPolls, 0);
    check("R3", "idle gap before poll", gapCnt, POLL);
  endtask

  task automatic tAnZero();
    int res;
    ctrlInit = 16'h0040; anHold = 0; errAt = 0;
    runCmd(1'b1, 0, 1'b0, res);
    check("R7", "zero timeout autoneg OK", res, 0);
    check("R7", "write issued", writeCnt, 1);
    check("R7", "no polls", readIdx, 1);
  endtask

  task automatic tResetZero();
    int res;
    ctrlInit = 16'h0000; resetHold = 0; errAt = 0;
    runCmd(1'b0, 0, 1'b0, res);
    check("R8", "zero timeout reset TIMEOUT", res, 2);
    check("R8", "write issued", writeCnt, 1);
    check("R8", "no polls", readIdx, 1);
  endtask

  task automatic tTimeouts();
    int res;
    ctrlInit = 16'h0000; anHold = 1000; resetHold = 1000; errAt = 0;
    runCmd(1'b1, 20, 1'b0, res);
    check("R6", "autoneg t=20 TIMEOUT", res, 2);
    check("R6", "autoneg t=20 polls", statPolls, 3);
    runCmd(1'b1, 16, 1'b0, res);
    check("R6", "autoneg t=16 TIMEOUT", res, 2);
    check("R6", "autoneg t=16 polls", statPolls, 2);
    runCmd(1'b0, 24, 1'b0, res);
    check("R6", "reset t=24 TIMEOUT", res, 2);
    check("R6", "reset t=24 polls", ctrlPolls, 3);
    runCmd(1'b0, 1, 1'b0, res);
    check("R6", "reset t=1 polls", ctrlPolls, 1);
  endtask

  task automatic tErrors();
    int res;
    ctrlInit = 16'h0000; anHold = 1000; resetHold = 1000;
    errAt = 1;
    runCmd(1'b0, 100, 1'b0, res);
    check("R9", "first read error FAIL", res, 1);
    check("R9", "no write after error", writeCnt, 0);
    errAt = 3;
    runCmd(1'b1, 100, 1'b0, res);
    check("R9", "poll error FAIL", res, 1);
    check("R9", "polls before error", statPolls, 2);
    errAt = 0;
  endtask

  task automatic tBusyIgnore();
    int res;
    ctrlInit = 16'h1140; resetHold = 0; anHold = 0; errAt = 0;
    runCmd(1'b0, 40, 1'b1, res);
    check("R11", "original command result", res, 0);
    check("R11", "single write", writeCnt, 1);
    check("R11", "write is reset kind", lastWdata, 16'h9140);
    check("R11", "no status reads", statPolls, 0);
    repeat (4) begin
      @(negedge clk);
      check("R11", "stays idle", busy, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tResetOk();
    tAnOk();
    tAnZero();
    tResetZero();
    tTimeouts();
    tErrors();
    tBusyIgnore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule